// File: doc/BRIEF.md
# Bit-Serial Unsigned Multiplier

This block multiplies a 4-bit unsigned multiplicand by a 4-bit unsigned multiplier and returns the 8-bit product. The multiplicand is loaded in parallel. The multiplier is fed in one bit per clock, least significant bit first. The product leaves on a single wire, one bit per clock, least significant bit first. A one-cycle pulse on `go` starts a job, and a one-cycle pulse on `fin` marks its end.

Inside the block there are four parts:
- a register that holds the multiplicand;
- a 4-bit shift register for the multiplier;
- a row of multiply-accumulate cells, one for each multiplicand bit, each with its own stored carry;
- a sequencer that runs eight iterations: four that take in multiplier bits, then four that take in zeros.

In each iteration the cells work from the most significant to the least significant:
1. Each cell forms its partial product as the multiplicand bit AND the multiplier register bit at the same position.
2. Each cell adds the partial product, its stored carry and the sum of the cell above it.
3. The sum of the lowest cell is the product bit for that iteration.

The interface has fixed timing and no back-pressure. Serial data must be presented in its cycles, and the product bits must be taken in theirs. A new job may start in the cycle in which `fin` is high, so jobs can run back to back.

Top module: `bitser_mult`

## Requirements
- R1: A `go` pulse that is sampled while the block is idle, or while `fin` is high, does four things: it captures `mcand`, clears the multiplier register, clears every stored carry, and starts eight iterations. Call the clock edge that samples this `go` edge 0.
- R2: `mplier_bit` is sampled at edges 1 to 4. The bit sampled at edge k+1 is multiplier bit k. At edges 5 to 8 the multiplier register shifts in zeros and `mplier_bit` is ignored. Each shift moves the register contents up one position and puts the new bit at position 0.
- R3: From edge k+1 to edge k+2, `prod_bit` carries bit k of the product of the captured multiplicand and the serial multiplier, for k = 0 to 7.
- R4: Each cell adds three bits: its partial product, its stored carry and the sum from the cell above (0 for the top cell). The carry out is the majority of those three bits. After the eighth iteration every stored carry is zero.
- R5: `fin` is high for exactly one cycle, from edge 9 to edge 10.
- R6: A `go` pulse sampled at edges 1 to 9 is ignored. The running job continues unchanged.
- R7: Changes on `mcand` after edge 0 do not affect the result. While the block is idle, `mplier_bit` and `mcand` have no effect, and `prod_bit` holds its value.
- R8: The reset is synchronous and active high. It returns the block to idle with `fin` and `prod_bit` at 0. A `go` pulse sampled together with reset is ignored.
- R9: A `go` pulse sampled at edge 10 starts the next job, with no idle cycle in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| go | input | 1 | One-cycle pulse that starts a multiplication |
| mcand | input | 4 | Multiplicand, parallel, captured together with `go` |
| mplier_bit | input | 1 | Multiplier, serial, least significant bit first |
| prod_bit | output | 1 | Product, serial, least significant bit first |
| fin | output | 1 | One-cycle completion pulse |

## Verification
Two events can fall in the same cycle: the completion pulse of one job and the start pulse of the next. The bench provokes this by raising `go` in the `fin` cycle on a random half of the jobs. It then checks that the following product comes out intact, with no gap between the jobs.

During every iteration and the tail cycle, the bench also drives random `go` pulses and random multiplicand values. These must be ignored, and every product is compared against the arithmetic product of the operands captured at edge 0.

// File: rtl/bsm_pkg.sv
package bsm_pkg;
  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_RUN  = 2'd1,
    SQ_TAIL = 2'd2,
    SQ_FIN  = 2'd3
  } seq_state_t;
endpackage

// File: rtl/bsm_ctrl.sv
module bsm_ctrl
  import bsm_pkg::*;
#(
  parameter int ITER      = 8,
  parameter int ZERO_FROM = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic go,
  output logic load,
  output logic step,
  output logic fill_zero,
  output logic fin
);
  localparam int CW = (ITER > 1) ? $clog2(ITER) : 1;
  localparam logic [CW-1:0] LAST_IDX = CW'(ITER - 1);
  localparam logic [CW-1:0] ZERO_IDX = CW'(ZERO_FROM);

  seq_state_t st_q, st_nx;
  logic [CW-1:0] cnt_q;
  logic last;

  assign load      = go && (st_q == SQ_IDLE || st_q == SQ_FIN);
  assign step      = (st_q == SQ_RUN);
  assign last      = step && (cnt_q == LAST_IDX);
  assign fill_zero = (cnt_q >= ZERO_IDX);
  assign fin       = (st_q == SQ_FIN);

  always_comb begin
    st_nx = st_q;
    unique case (st_q)
      SQ_IDLE: if (load) st_nx = SQ_RUN;
      SQ_RUN:  if (last) st_nx = SQ_TAIL;
      SQ_TAIL: st_nx = SQ_FIN;
      SQ_FIN:  st_nx = load ? SQ_RUN : SQ_IDLE;
      default: st_nx = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= SQ_IDLE;
      cnt_q <= '0;
    end else begin
      st_q <= st_nx;
      if (load || last) cnt_q <= '0;
      else if (step)    cnt_q <= cnt_q + CW'(1);
    end
  end

  AST_FIN_PULSE: assert property (@(posedge clk) disable iff (rst) fin |=> !fin); // R5
  AST_FIN_AFTER_TAIL: assert property (@(posedge clk) disable iff (rst) (st_q == SQ_TAIL) |=> fin); // R5
  AST_GO_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (step && !last && go) |=> (step && cnt_q == $past(cnt_q) + CW'(1))); // R6
  AST_TAIL_IGNORES_GO: assert property (@(posedge clk) disable iff (rst) (st_q == SQ_TAIL) |-> !load); // R6
  AST_BACK_TO_BACK: assert property (@(posedge clk) disable iff (rst) (fin && go) |=> (step && cnt_q == '0)); // R9
  AST_RESET_IDLE: assert property (@(posedge clk) rst |=> (!fin && !step)); // R8
endmodule

// File: rtl/bsm_bshift.sv
module bsm_bshift #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         en,
  input  logic         zero_fill,
  input  logic         bit_in,
  output logic [N-1:0] b_nx
);
  logic [N-1:0] b_q;
  logic         ins;

  assign ins  = zero_fill ? 1'b0 : bit_in;
  assign b_nx = {b_q[N-2:0], ins};

  always_ff @(posedge clk) begin
    if (rst || clr) b_q <= '0;
    else if (en)    b_q <= b_nx;
  end

  AST_B_SHIFT: assert property (@(posedge clk) disable iff (rst)
    (en && !clr) |=> (b_q[N-1:1] == $past(b_q[N-2:0]))); // R2
  AST_ZERO_FILL: assert property (@(posedge clk) disable iff (rst)
    (en && zero_fill && !clr) |=> (b_q[0] == 1'b0)); // R2
  AST_B_CLEAR: assert property (@(posedge clk) disable iff (rst) clr |=> (b_q == '0)); // R1
endmodule

// File: rtl/bsm_cell.sv
module bsm_cell (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic en,
  input  logic a_bit,
  input  logic b_bit,
  input  logic sum_up,
  output logic sum_out,
  output logic cy_q
);
  logic pp, cy_nx;

  assign pp      = a_bit & b_bit;
  assign sum_out = pp ^ cy_q ^ sum_up;
  assign cy_nx   = (pp & cy_q) | (pp & sum_up) | (cy_q & sum_up);

  always_ff @(posedge clk) begin
    if (rst || clr) cy_q <= 1'b0;
    else if (en)    cy_q <= cy_nx;
  end

  AST_CARRY_CLEAR: assert property (@(posedge clk) disable iff (rst) clr |=> !cy_q); // R1
  AST_CARRY_HOLD: assert property (@(posedge clk) disable iff (rst) (!en && !clr) |=> $stable(cy_q)); // R4
endmodule

// File: rtl/bitser_mult.sv
module bitser_mult #(
  parameter int OPW = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           go,
  input  logic [OPW-1:0] mcand,
  input  logic           mplier_bit,
  output logic           prod_bit,
  output logic           fin
);
  localparam int ITER = 2 * OPW;

  logic           load, step, fill_zero;
  logic [OPW-1:0] a_q, b_nx, cy_vec;
  logic [OPW:0]   sum_chain;

  bsm_ctrl #(.ITER(ITER), .ZERO_FROM(OPW)) u_ctrl (
    .clk(clk), .rst(rst), .go(go),
    .load(load), .step(step), .fill_zero(fill_zero), .fin(fin)
  );

  bsm_bshift #(.N(OPW)) u_bsh (
    .clk(clk), .rst(rst), .clr(load), .en(step),
    .zero_fill(fill_zero), .bit_in(mplier_bit), .b_nx(b_nx)
  );

  always_ff @(posedge clk) begin
    if (rst)       a_q <= '0;
    else if (load) a_q <= mcand;
  end

  assign sum_chain[OPW] = 1'b0;

  for (genvar j = OPW - 1; j >= 0; j--) begin : g_cell
    bsm_cell u_cell (
      .clk(clk), .rst(rst), .clr(load), .en(step),
      .a_bit(a_q[j]), .b_bit(b_nx[j]),
      .sum_up(sum_chain[j+1]), .sum_out(sum_chain[j]),
      .cy_q(cy_vec[j])
    );
  end

  always_ff @(posedge clk) begin
    if (rst)       prod_bit <= 1'b0;
    else if (step) prod_bit <= sum_chain[0];
  end

  AST_CARRIES_DRAINED: assert property (@(posedge clk) disable iff (rst) fin |-> (cy_vec == '0)); // R4
  AST_A_HELD: assert property (@(posedge clk) disable iff (rst) (step && !load) |=> $stable(a_q)); // R7
  AST_OUT_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst) !step |=> $stable(prod_bit)); // R7
  AST_RESET_OUT: assert property (@(posedge clk) rst |=> (!prod_bit && !fin)); // R8
endmodule

// File: tb/bitser_mult_bench.sv
module bitser_mult_bench;
  localparam int N = 4;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         go = 1'b0;
  logic [N-1:0] mcand = '0;
  logic         mplier_bit = 1'b0;
  logic         prod_bit, fin;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int seed_val;

  always #4 clk = ~clk;

  bitser_mult #(.OPW(N)) u_bitser_mult (
    .clk(clk), .rst(rst), .go(go), .mcand(mcand),
    .mplier_bit(mplier_bit), .prod_bit(prod_bit), .fin(fin)
  );

  function automatic logic [2*N-1:0] exp_prod(input logic [N-1:0] a, input logic [N-1:0] b);
    return (2*N)'(a) * (2*N)'(b);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // One job. If preloaded, go/mcand were driven at the previous falling edge.
  task automatic do_mult(input logic [N-1:0] a, input logic [N-1:0] b, input bit preloaded,
                         input bit noise, input bit chain, input logic [N-1:0] na);
    logic [2*N-1:0] got;
    got = '0;
    if (!preloaded) begin
      @(negedge clk);
      mcand = a; go = 1'b1; mplier_bit = 1'($urandom);
    end
    @(posedge clk); // edge 0
    for (int k = 0; k <= 9; k++) begin
      @(negedge clk); // after edge k
      if (k == 0) chk(fin == 1'b0, "R5 fin low at start", int'(fin), 0);
      if (k >= 1 && k <= 8) got[k-1] = prod_bit;
      if (k == 8) chk(fin == 1'b0, "R5 fin low in tail", int'(fin), 0);
      if (k == 9) begin
        chk(fin == 1'b1, "R5 fin high after edge 9", int'(fin), 1);
        chk(got == exp_prod(a, b), "R3 R4 product", int'(got), int'(exp_prod(a, b)));
      end
      mplier_bit = (k < N) ? b[k] : 1'($urandom);   // R2 zero fill ignores input
      if (noise) begin
        mcand = N'($urandom);                         // R7
        go    = (k <= 8) ? 1'($urandom) : 1'b0;       // R6
      end else begin
        go = 1'b0;
      end
      if (k == 9 && chain) begin                      // R9
        go = 1'b1; mcand = na;
      end
    end
  endtask

  initial begin
    logic [N-1:0] ca, cb, na;
    bit c_now, c_nxt;
    logic hold;
    seed_val = $urandom(32'd20240611);

    // R8: reset with go held high
    go = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(fin == 1'b0, "R8 fin after reset", int'(fin), 0);
    chk(prod_bit == 1'b0, "R8 prod_bit after reset", int'(prod_bit), 0);
    rst = 1'b0; go = 1'b0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      chk(fin == 1'b0, "R8 go during reset ignored", int'(fin), 0);
    end

    // directed corners
    do_mult(4'hF, 4'hF, 1'b0, 1'b0, 1'b0, 4'h0);
    do_mult(4'h0, 4'hF, 1'b0, 1'b1, 1'b0, 4'h0);
    do_mult(4'hF, 4'h1, 1'b0, 1'b1, 1'b1, 4'h8);
    do_mult(4'h8, 4'h8, 1'b1, 1'b1, 1'b0, 4'h0);   // R9 back to back

    // R7: idle inputs have no effect
    @(negedge clk);
    hold = prod_bit;
    for (int i = 0; i < 6; i++) begin
      mplier_bit = 1'($urandom); mcand = N'($urandom);
      @(negedge clk);
      chk(prod_bit == hold, "R7 idle prod_bit held", int'(prod_bit), int'(hold));
      chk(fin == 1'b0, "R7 idle fin low", int'(fin), 0);
    end

    // all operand pairs, random chaining and noise
    c_now = 1'b0;
    ca = 4'h0; cb = 4'h0;
    for (int p = 0; p < 256; p++) begin
      c_nxt = (p < 255) ? 1'($urandom) : 1'b0;
      na = N'((p + 1) >> N);
      do_mult(ca, cb, c_now, 1'($urandom), c_nxt, na);
      ca = N'((p + 1) >> N);
      cb = N'(p + 1);
      c_now = c_nxt;
    end

    // R8: reset in the middle of a job, then a clean job
    @(negedge clk);
    mcand = 4'hD; go = 1'b1;
    @(negedge clk);
    go = 1'b0; mplier_bit = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b1; go = 1'b1;
    @(negedge clk);
    chk(prod_bit == 1'b0, "R8 mid-run reset prod_bit", int'(prod_bit), 0);
    chk(fin == 1'b0, "R8 mid-run reset fin", int'(fin), 0);
    rst = 1'b0; go = 1'b0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      chk(fin == 1'b0, "R8 no fin after reset", int'(fin), 0);
    end

    // random jobs (R1 R3)
    for (int i = 0; i < 100; i++)
      do_mult(N'($urandom), N'($urandom), 1'b0, 1'($urandom), 1'b0, 4'h0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule